// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block holds the 15-bit program counter of an 8-bit processor whose instructions are one to three bytes long. In every cycle where the sequencer asserts the step strobe, it selects the next PC. The choices are a straight advance, a skip over the following instruction, a full-width jump, a jump inside the current 4 KiB page, a short relative branch taken from the opcode, a software trap, a table jump through a ROM byte, or a return through two popped stack bytes. When the strobe is low, the counter keeps its value.

The block also forms the ROM address used by table lookups. The high part of that address comes from the advanced PC and the low byte is the accumulator. Every relative, paged and table computation uses the PC that has already moved past the current instruction. A skip moves the PC over the next instruction, whose length the decoder supplies. If that next instruction is the two-byte direct-address prefix, the PC also moves over the instruction the prefix modifies.

Top module: `pc_step_unit`

## Requirements
- R1: After reset `pc_o` is 0x0000. While `step_i` is low, `pc_o` keeps its value whatever the other inputs do.
- R2: Class 0 (sequential) loads `pc_o + len_i`, taken modulo 2^15, so the counter wraps from the top of the space to the bottom.
- R3: In class 0 with `skip_i` high, the load also adds `next_len_i`. If `next_dir_i` is also high, it adds `after_len_i` as well. With `skip_i` low, the three skip inputs have no effect.
- R4: Class 1 (long jump) loads `{op1_i[6:0], op2_i}`. Bit 7 of `op1_i` is ignored.
- R5: Class 2 (paged jump) loads bits 14..12 of the advanced PC (`pc_o + len_i`), then `opcode_i[3:0]`, then `op1_i`.
- R6: Class 3 (relative jump) loads the advanced PC plus a signed 6-bit offset `{opcode_i[7], opcode_i[4:0]}`, taken modulo 2^15. Opcode 000ddddd therefore moves forward by d, and 111ddddd moves by d − 32.
- R7: Class 4 (trap) loads 0x00FF.
- R8: Class 5 (table jump) loads `{adv[14:8], rom_byte_i}`, where adv is the advanced PC.
- R9: `tbl_addr_o` is combinationally `{adv[14:8], acc_i}`. Class 6 (table load) advances the PC as in class 0 without a skip.
- R10: Class 7 (return) loads `{pop_hi_i[6:0], pop_lo_i}`. Class 8 (return-and-skip) loads the same address plus the skip span from R3, applied unconditionally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| step_i | input | 1 | Load the next PC at this edge |
| kind_i | input | 4 | Instruction class code (0..8, see requirements) |
| opcode_i | input | 8 | Opcode byte of the current instruction |
| len_i | input | 2 | Length of the current instruction in bytes (1..3) |
| op1_i | input | 8 | First operand byte |
| op2_i | input | 8 | Second operand byte |
| acc_i | input | 8 | Accumulator, low byte of the table address |
| rom_byte_i | input | 8 | Byte returned by the table lookup |
| pop_hi_i | input | 8 | Popped high byte of the return address |
| pop_lo_i | input | 8 | Popped low byte of the return address |
| skip_i | input | 1 | Pending skip of the next instruction |
| next_len_i | input | 2 | Length of the instruction to be skipped |
| next_dir_i | input | 1 | Instruction to be skipped is the direct-address prefix |
| after_len_i | input | 2 | Length of the instruction that follows that prefix |
| pc_o | output | 15 | Current program counter |
| tbl_addr_o | output | 15 | ROM address for table lookups |

## Verification
A new `pc_o` is due one clock edge after the edge where `step_i` is sampled high. The scoreboard's driver places the inputs at the falling edge and queues the value it computes itself. The monitor reads `pc_o` two nanoseconds after the following rising edge and pops one entry for each edge that had the strobe high. `tbl_addr_o` has no register in its path. The driver therefore checks it in the same half-cycle, one nanosecond after it sets the accumulator.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [3:0] {
    K_SEQ   = 4'd0,
    K_LONG  = 4'd1,
    K_PAGE  = 4'd2,
    K_REL   = 4'd3,
    K_TRAP  = 4'd4,
    K_TJMP  = 4'd5,
    K_TLOAD = 4'd6,
    K_RET   = 4'd7,
    K_RETSK = 4'd8
  } pc_kind_e;
endpackage

// File: rtl/pcu_advance.sv
module pcu_advance #(
  parameter int PC_W  = 15,
  parameter int LEN_W = 2
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [LEN_W-1:0] next_len_i,
  input  logic             next_dir_i,
  input  logic [LEN_W-1:0] after_len_i,
  output logic [PC_W-1:0]  adv_o,
  output logic [PC_W-1:0]  span_o
);
  localparam int SPAN_W = LEN_W + 1;

  logic [SPAN_W-1:0] span_w;

  always_comb begin
    adv_o  = pc_i + PC_W'(len_i);
    span_w = SPAN_W'(next_len_i) + (next_dir_i ? SPAN_W'(after_len_i) : SPAN_W'(0));
    span_o = PC_W'(span_w);
  end
endmodule

// File: rtl/pcu_target.sv
module pcu_target #(
  parameter int PC_W     = 15,
  parameter int BYTE_W   = 8,
  parameter int PAGE_W   = 12,
  parameter int REL_W    = 5,
  parameter int TRAP_VEC = 255
) (
  input  pcu_pkg::pc_kind_e kind_i,
  input  logic [PC_W-1:0]   adv_i,
  input  logic [PC_W-1:0]   span_i,
  input  logic              skip_i,
  input  logic [BYTE_W-1:0] opcode_i,
  input  logic [BYTE_W-1:0] op1_i,
  input  logic [BYTE_W-1:0] op2_i,
  input  logic [BYTE_W-1:0] rom_byte_i,
  input  logic [BYTE_W-1:0] pop_hi_i,
  input  logic [BYTE_W-1:0] pop_lo_i,
  output logic [PC_W-1:0]   next_o
);
  import pcu_pkg::*;

  localparam int HI_W   = PC_W - BYTE_W;
  localparam int PSEL_W = PAGE_W - BYTE_W;
  localparam int EXT_W  = PC_W - REL_W - 1;

  logic [PC_W-1:0] rel_off;
  logic [PC_W-1:0] ret_addr;

  always_comb begin
    rel_off  = {{EXT_W{opcode_i[BYTE_W-1]}}, opcode_i[BYTE_W-1], opcode_i[REL_W-1:0]};
    ret_addr = {pop_hi_i[HI_W-1:0], pop_lo_i};
    unique case (kind_i)
      K_SEQ:   next_o = skip_i ? adv_i + span_i : adv_i;
      K_LONG:  next_o = {op1_i[HI_W-1:0], op2_i};
      K_PAGE:  next_o = {adv_i[PC_W-1:PAGE_W], opcode_i[PSEL_W-1:0], op1_i};
      K_REL:   next_o = adv_i + rel_off;
      K_TRAP:  next_o = PC_W'(TRAP_VEC);
      K_TJMP:  next_o = {adv_i[PC_W-1:BYTE_W], rom_byte_i};
      K_TLOAD: next_o = adv_i;
      K_RET:   next_o = ret_addr;
      K_RETSK: next_o = ret_addr + span_i;
      default: next_o = adv_i;
    endcase
  end
endmodule

// File: rtl/pc_step_unit.sv
module pc_step_unit #(
  parameter int PC_W   = 15,
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 2,
  parameter int KIND_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic [BYTE_W-1:0] opcode_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [BYTE_W-1:0] op1_i,
  input  logic [BYTE_W-1:0] op2_i,
  input  logic [BYTE_W-1:0] acc_i,
  input  logic [BYTE_W-1:0] rom_byte_i,
  input  logic [BYTE_W-1:0] pop_hi_i,
  input  logic [BYTE_W-1:0] pop_lo_i,
  input  logic              skip_i,
  input  logic [LEN_W-1:0]  next_len_i,
  input  logic              next_dir_i,
  input  logic [LEN_W-1:0]  after_len_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [PC_W-1:0]   tbl_addr_o
);
  import pcu_pkg::*;

  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_d;
  logic [PC_W-1:0] adv_w;
  logic [PC_W-1:0] span_w;
  logic [PC_W-1:0] tgt_w;
  pc_kind_e        kind_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign kind_w = pc_kind_e'(kind_i);

  pcu_advance #(.PC_W(PC_W), .LEN_W(LEN_W)) u_adv (
    .pc_i        (pc_q),
    .len_i       (len_i),
    .next_len_i  (next_len_i),
    .next_dir_i  (next_dir_i),
    .after_len_i (after_len_i),
    .adv_o       (adv_w),
    .span_o      (span_w)
  );

  pcu_target #(.PC_W(PC_W), .BYTE_W(BYTE_W)) u_tgt (
    .kind_i     (kind_w),
    .adv_i      (adv_w),
    .span_i     (span_w),
    .skip_i     (skip_i),
    .opcode_i   (opcode_i),
    .op1_i      (op1_i),
    .op2_i      (op2_i),
    .rom_byte_i (rom_byte_i),
    .pop_hi_i   (pop_hi_i),
    .pop_lo_i   (pop_lo_i),
    .next_o     (tgt_w)
  );

  always_comb begin
    pc_d = pc_q;
    if (step_i) pc_d = tgt_w;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) pc_q <= '0;
    else            pc_q <= pc_d;
  end

  assign pc_o       = pc_q;
  assign tbl_addr_o = {adv_w[PC_W-1:BYTE_W], acc_i};
endmodule

// File: rtl/pc_step_unit_chk.sv
module pc_step_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        step_i,
  input logic [3:0]  kind_i,
  input logic [7:0]  opcode_i,
  input logic [1:0]  len_i,
  input logic [7:0]  op1_i,
  input logic [7:0]  op2_i,
  input logic [7:0]  rom_byte_i,
  input logic [7:0]  pop_hi_i,
  input logic [7:0]  pop_lo_i,
  input logic [14:0] pc_o
);
  logic [14:0] fwd_chk;
  assign fwd_chk = pc_o + {13'd0, len_i};

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(pc_o)); // R1

  AST_LONG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && kind_i == 4'd1) |=> pc_o == {$past(op1_i[6:0]), $past(op2_i)}); // R4

  AST_PAGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && kind_i == 4'd2) |=> pc_o[14:12] == $past(fwd_chk[14:12])); // R5

  AST_TRAP_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && kind_i == 4'd4) |=> pc_o == 15'h00FF); // R7

  AST_TBL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && kind_i == 4'd5) |=> pc_o[7:0] == $past(rom_byte_i)); // R8

  AST_TBL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && kind_i == 4'd5) |=> pc_o[14:8] == $past(fwd_chk[14:8])); // R8

  AST_RET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && kind_i == 4'd7) |=> pc_o == {$past(pop_hi_i[6:0]), $past(pop_lo_i)}); // R10

  AST_REL_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && kind_i == 4'd3 && !opcode_i[7]) |=> pc_o != $past(pc_o)); // R6
endmodule

bind pc_step_unit pc_step_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .step_i     (step_i),
  .kind_i     (kind_i),
  .opcode_i   (opcode_i),
  .len_i      (len_i),
  .op1_i      (op1_i),
  .op2_i      (op2_i),
  .rom_byte_i (rom_byte_i),
  .pop_hi_i   (pop_hi_i),
  .pop_lo_i   (pop_lo_i),
  .pc_o       (pc_o)
);

// File: tb/tb_pc_step_unit.sv
`timescale 1ns/1ps
module tb_pc_step_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_i;
  logic [3:0]  kind_i;
  logic [7:0]  opcode_i;
  logic [1:0]  len_i;
  logic [7:0]  op1_i, op2_i, acc_i, rom_byte_i, pop_hi_i, pop_lo_i;
  logic        skip_i, next_dir_i;
  logic [1:0]  next_len_i, after_len_i;
  logic [14:0] pc_o, tbl_addr_o;

  int n_vec = 0;
  int n_bad = 0;
  logic [14:0] mpc;
  logic [14:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #4 clk = ~clk;

  pc_step_unit dut (.*);

  task automatic chk(input string tag, input logic [14:0] act, input logic [14:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clr();
    step_i = 0; kind_i = 0; opcode_i = 0; len_i = 1; op1_i = 0; op2_i = 0;
    acc_i = 0; rom_byte_i = 0; pop_hi_i = 0; pop_lo_i = 0;
    skip_i = 0; next_len_i = 0; next_dir_i = 0; after_len_i = 0;
  endtask

  // driver: inputs are set by the caller; this strobes one step and queues the result
  task automatic issue(input logic [14:0] exp, input string tag);
    step_i = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    mpc = exp;
    @(negedge clk);
    clr();
  endtask

  task automatic go_long(input logic [14:0] a);
    kind_i = 4'd1; op1_i = {1'b0, a[14:8]}; op2_i = a[7:0];
    issue(a, "R4 long preset");
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      if (step_i === 1'b1) begin
        #2;
        if (exp_q.size() == 0) chk("R1 unexpected step", pc_o, 15'h0);
        else chk(tag_q.pop_front(), pc_o, exp_q.pop_front());
      end
    end
  end

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    clr();
    rst_n = 1'b0;
    mpc = 15'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset value", pc_o, 15'h0000);

    // R1: step low with a jump class present
    kind_i = 4'd1; op1_i = 8'h12; op2_i = 8'h34;
    repeat (3) @(negedge clk);
    chk("R1 hold without step", pc_o, 15'h0000);
    clr();

    // R2 sequential
    len_i = 1; issue(15'h0001, "R2 seq len1");
    len_i = 3; issue(15'h0004, "R2 seq len3");
    go_long(15'h7FFF);
    len_i = 2; issue(15'h0001, "R2 seq wrap");

    // R4 with bit7 of op1 set
    kind_i = 1; op1_i = 8'hFA; op2_i = 8'h34; issue(15'h7A34, "R4 long ignores op1 bit7");

    // R3 skip
    go_long(15'h1000);
    len_i = 1; skip_i = 1; next_len_i = 2; issue(15'h1003, "R3 skip next len2");
    len_i = 2; skip_i = 1; next_len_i = 2; next_dir_i = 1; after_len_i = 1;
    issue(15'h1008, "R3 skip prefix pair");
    len_i = 1; skip_i = 0; next_len_i = 3; next_dir_i = 1; after_len_i = 3;
    issue(15'h1009, "R3 no skip ignores span");

    // R5 paged, advanced PC crosses into next page group
    go_long(15'h5FFE);
    kind_i = 2; len_i = 2; opcode_i = 8'h2A; op1_i = 8'hBC; issue(15'h6ABC, "R5 paged keeps adv top");

    // R6 relative
    go_long(15'h1000);
    kind_i = 3; len_i = 1; opcode_i = 8'h1F; issue(15'h1020, "R6 forward 31");
    go_long(15'h0010);
    kind_i = 3; len_i = 1; opcode_i = 8'hE0; issue(15'h7FF1, "R6 backward 32 wrap");
    go_long(15'h0100);
    kind_i = 3; len_i = 1; opcode_i = 8'hFF; issue(15'h0100, "R6 backward 1");

    // R7 trap
    kind_i = 4; len_i = 1; opcode_i = 8'h00; issue(15'h00FF, "R7 trap vector");

    // R8 table jump, R9 table address
    go_long(15'h32FF);
    kind_i = 5; len_i = 1; acc_i = 8'h45; rom_byte_i = 8'h9A;
    #1 chk("R9 table address tjmp", tbl_addr_o, 15'h3345);
    issue(15'h339A, "R8 table jump low byte");
    go_long(15'h2010);
    kind_i = 6; len_i = 1; acc_i = 8'h77; rom_byte_i = 8'h11;
    #1 chk("R9 table address tload", tbl_addr_o, 15'h2077);
    issue(15'h2011, "R9 table load sequential");

    // R10 returns
    kind_i = 7; pop_hi_i = 8'hC5; pop_lo_i = 8'h12; issue(15'h4512, "R10 return");
    kind_i = 8; pop_hi_i = 8'h45; pop_lo_i = 8'h12; next_len_i = 3; issue(15'h4515, "R10 return skip");
    kind_i = 8; pop_hi_i = 8'h7F; pop_lo_i = 8'hFE; next_len_i = 2; next_dir_i = 1; after_len_i = 3;
    issue(15'h0003, "R10 return skip prefix wrap");

    repeat (2) @(negedge clk);
    chk("R1 hold after run", pc_o, mpc);
    if (exp_q.size() != 0) chk("R1 pending results", 15'(exp_q.size()), 15'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule